// File: doc/BRIEF.md
# Threshold-Refill Hub Prefetch FIFO

This block is a read-ahead queue placed between a shared memory hub and a streaming consumer. The hub is split into eight slices that rotate past each port, one slice per clock. A long address is served when its slice comes round to the port. After a start strobe the block flushes itself, takes the start long address and reads consecutive longs from the hub. It keeps reading while the number of stored longs is below a low-water mark. The consumer takes longs through a pop port and sees each one, with a valid flag, one cycle later.

Hub read data returns a fixed number of clocks after each grant, so some reads are still in flight when the block stops asking. The storage holds NPROC+11 longs, where NPROC is the number of processors sharing the hub. The refill mark is NPROC+7. The block counts its outstanding reads so that stored plus in-flight longs can never exceed the storage. Its hub access has priority over the owning processor's own hub transfers. The processor port is merged onto the same hub request and is granted only when the prefetcher is not asking.

Top module: `hub_prefetch_fifo`

## Requirements
- R1: After reset the block is idle. It makes no hub request of its own, `pop_valid` is 0, and `hub_req`/`hub_addr` follow `cpu_req`/`cpu_addr`, so the processor port can be granted.
- R2: A cycle with `start`=1 empties the storage, drops every read still in flight, ignores a `pop` and any hub grant in that cycle, and loads `start_addr`. The first long delivered afterwards is the word at `start_addr`.
- R3: Stored plus in-flight longs never exceed NPROC+11. A full refill from empty with no pops fetches exactly NPROC+11 longs, with the default LAT of 5.
- R4: The block requests the hub when it has been started, fewer than NPROC+7 longs are stored, and stored plus in-flight longs are fewer than NPROC+11. Otherwise it makes no request of its own.
- R5: Each hub grant to the block advances its long address by one, modulo 2^ADDR_W. Longs reach the consumer in address order.
- R6: Read data for a grant taken in cycle c is captured from `hub_rdata` at the end of cycle c+LAT. With `pop` held high from the start, the first `pop_valid` appears LAT+2 cycles after the first grant.
- R7: While the block requests the hub, `hub_addr` carries its address and `cpu_gnt` is 0. Otherwise `hub_addr`=`cpu_addr` and `cpu_gnt`=`cpu_req`&`hub_gnt`. At most one of the two owners is granted in any cycle.
- R8: `pop` in a cycle with stored data gives `pop_valid`=1 and the head long on `pop_data` in the next cycle. `pop` with nothing stored is ignored: `pop_valid` is 0 in the next cycle and no data is lost.
- R9: A pop and a hub data arrival in the same cycle both take effect. Neither long is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Flush and restart from `start_addr` |
| start_addr | input | ADDR_W | First long address of the stream |
| pop | input | 1 | Consumer takes the head long |
| pop_valid | output | 1 | `pop_data` holds a popped long this cycle |
| pop_data | output | DATA_W | Popped long |
| hub_req | output | 1 | Hub access wanted (prefetcher or processor) |
| hub_addr | output | ADDR_W | Long address for the hub; low 3 bits select the slice |
| hub_gnt | input | 1 | Hub serves `hub_addr` this cycle |
| hub_rdata | input | DATA_W | Hub read data, LAT cycles after a grant |
| cpu_req | input | 1 | Processor hub transfer request |
| cpu_addr | input | ADDR_W | Processor long address |
| cpu_gnt | output | 1 | Processor transfer served this cycle |

## Verification
Two events can fall in the same clock: the consumer popping the head and a hub read landing in the tail, and a start strobe landing while reads are still in flight. The bench drives pops at fixed periods of 1, 2, 3 and 9 clocks against a rotating-slice hub model. This makes arrivals and pops line up in many phases. It counts the coincident cycles and compares every popped long against a queue-based model. The bench also restarts the stream in the middle of a burst, at an address near the top of the space. It then checks that no stale long is delivered and that the first long is the word at the new address.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    // Storage holds the processor count plus a fixed margin for reads in flight.
    function automatic int fifo_depth(input int nproc);
        return nproc + 11;
    endfunction

    // Low-water mark below which refill requests are issued.
    function automatic int fifo_mark(input int nproc);
        return nproc + 7;
    endfunction

    typedef enum logic [0:0] {
        OWNER_CPU  = 1'b0,
        OWNER_FIFO = 1'b1
    } hub_owner_e;

endpackage

// File: rtl/hpf_store.sv
module hpf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 19
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             count;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (wr_en) begin
                st_d.mem[st_q.wr_ptr] = wr_data;
                st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
            end
            if (rd_en) begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
            st_d.count = st_q.count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign count = st_q.count;

    AST_STORE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !flush) |-> (st_q.count < CNT_W'(DEPTH)))
        else $error("store written while full"); // R3

    AST_STORE_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush) |-> (st_q.count != '0))
        else $error("store read while empty"); // R8

endmodule

// File: rtl/hpf_refill.sv
module hpf_refill #(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 19,
    parameter int MARK   = 15,
    parameter int LAT    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic [$clog2(DEPTH+1)-1:0]   occupancy,
    input  logic                         gnt,
    output logic                         req,
    output logic [ADDR_W-1:0]            addr,
    output logic                         arrive,
    output logic [$clog2(LAT+1)-1:0]     inflight
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int INF_W = $clog2(LAT + 1);

    typedef struct packed {
        logic              run;
        logic [ADDR_W-1:0] addr;
        logic [LAT-1:0]    tag;
        logic [INF_W-1:0]  infl;
    } refill_t;

    refill_t rf_d, rf_q;

    logic [CNT_W:0] total;
    logic           take;

    assign total  = {1'b0, occupancy} + (CNT_W+1)'(rf_q.infl);
    assign req    = rf_q.run
                 && (occupancy < CNT_W'(MARK))
                 && (total < (CNT_W+1)'(DEPTH));
    assign take   = req && gnt && !start;
    assign arrive = rf_q.tag[LAT-1];

    always_comb begin
        rf_d = rf_q;
        if (start) begin
            rf_d.run  = 1'b1;
            rf_d.addr = start_addr;
            rf_d.tag  = '0;
            rf_d.infl = '0;
        end else begin
            rf_d.tag  = (rf_q.tag << 1) | LAT'(take);
            rf_d.infl = rf_q.infl + INF_W'(take) - INF_W'(arrive);
            rf_d.addr = rf_q.addr + ADDR_W'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign addr     = rf_q.addr;
    assign inflight = rf_q.infl;

    AST_INFLIGHT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rf_q.infl) == $countones(rf_q.tag))
        else $error("in-flight count disagrees with latency pipe"); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take) |=> (rf_q.addr == $past(rf_q.addr) + ADDR_W'(1)))
        else $error("address did not step after grant"); // R5

    AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_q.run) |-> (!req && rf_q.tag == '0))
        else $error("request before first start"); // R1

endmodule

// File: rtl/hpf_arb.sv
module hpf_arb #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_req,
    input  logic [ADDR_W-1:0] fifo_addr,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              hub_gnt,
    output logic              hub_req,
    output logic [ADDR_W-1:0] hub_addr,
    output logic              fifo_gnt,
    output logic              cpu_gnt
);

    import hpf_pkg::*;

    hub_owner_e owner;

    always_comb begin
        owner    = fifo_req ? OWNER_FIFO : OWNER_CPU;
        hub_req  = fifo_req || cpu_req;
        hub_addr = (owner == OWNER_FIFO) ? fifo_addr : cpu_addr;
        fifo_gnt = (owner == OWNER_FIFO) && hub_gnt;
        cpu_gnt  = (owner == OWNER_CPU) && cpu_req && hub_gnt;
    end

    AST_CPU_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_req |-> !cpu_gnt)
        else $error("processor granted over prefetcher"); // R7

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_gnt, cpu_gnt}))
        else $error("two owners granted"); // R7

endmodule

// File: rtl/hub_prefetch_fifo.sv
module hub_prefetch_fifo #(
    parameter int NPROC  = 8,
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32,
    parameter int LAT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              pop,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              hub_req,
    output logic [ADDR_W-1:0] hub_addr,
    input  logic              hub_gnt,
    input  logic [DATA_W-1:0] hub_rdata,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_gnt
);

    import hpf_pkg::*;

    localparam int DEPTH = fifo_depth(NPROC);
    localparam int MARK  = fifo_mark(NPROC);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int INF_W = $clog2(LAT + 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    logic [CNT_W-1:0]  occupancy;
    logic [INF_W-1:0]  inflight;
    logic [DATA_W-1:0] head;
    logic [ADDR_W-1:0] fifo_addr;
    logic              fifo_req;
    logic              fifo_gnt;
    logic              arrive;
    logic              wr_ok;
    logic              pop_ok;

    assign pop_ok = pop && (occupancy != '0) && !start;
    assign wr_ok  = arrive && !start;

    hpf_refill #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .MARK   (MARK),
        .LAT    (LAT)
    ) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .occupancy  (occupancy),
        .gnt        (fifo_gnt),
        .req        (fifo_req),
        .addr       (fifo_addr),
        .arrive     (arrive),
        .inflight   (inflight)
    );

    hpf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (start),
        .wr_en   (wr_ok),
        .wr_data (hub_rdata),
        .rd_en   (pop_ok),
        .head    (head),
        .count   (occupancy)
    );

    hpf_arb #(
        .ADDR_W (ADDR_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_req  (fifo_req),
        .fifo_addr (fifo_addr),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .hub_gnt   (hub_gnt),
        .hub_req   (hub_req),
        .hub_addr  (hub_addr),
        .fifo_gnt  (fifo_gnt),
        .cpu_gnt   (cpu_gnt)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = pop_ok;
        if (pop_ok) out_d.data = head;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pop_valid = out_q.valid;
    assign pop_data  = out_q.data;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occupancy} + (CNT_W+1)'(inflight)) <= (CNT_W+1)'(DEPTH))
        else $error("stored plus in-flight exceeds depth"); // R3

    AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (occupancy == '0 && inflight == '0 && !pop_valid))
        else $error("start did not flush"); // R2

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && occupancy == '0) |=> !pop_valid)
        else $error("pop on empty produced data"); // R8

endmodule

// File: tb/hub_prefetch_fifo_bench.sv
module hub_prefetch_fifo_bench;

    localparam int NP    = 8;
    localparam int AW    = 17;
    localparam int DW    = 32;
    localparam int LAT   = 5;
    localparam int DEPTH = NP + 11;
    localparam int MARK  = NP + 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, pop, hub_gnt, cpu_req;
    logic [AW-1:0] start_addr, cpu_addr;
    logic [DW-1:0] hub_rdata;
    logic          pop_valid, hub_req, cpu_gnt;
    logic [DW-1:0] pop_data;
    logic [AW-1:0] hub_addr;

    always #10 clk = ~clk;

    hub_prefetch_fifo #(.NPROC(NP), .ADDR_W(AW), .DATA_W(DW), .LAT(LAT)) u_hub_prefetch_fifo (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .pop(pop), .pop_valid(pop_valid), .pop_data(pop_data),
        .hub_req(hub_req), .hub_addr(hub_addr), .hub_gnt(hub_gnt), .hub_rdata(hub_rdata),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_gnt(cpu_gnt)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // scenario controls
    logic          drv_start = 0;
    logic [AW-1:0] drv_addr = '0;
    logic          drv_cpu = 0;
    int            pop_period = 0;

    // observations
    int cyc = 0;
    int fifo_grants = 0;
    int cpu_grants = 0;
    int coincide = 0;
    int empty_pops = 0;
    int first_gnt_cyc = -1;
    int first_pv_cyc = -1;
    logic [DW-1:0] first_pv_data = '0;

    // reference model
    bit            m_run;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_q[$];
    int            m_pend_due[$];
    logic [AW-1:0] m_pend_addr[$];
    bit            m_pv;
    logic [DW-1:0] m_pd;
    // hub physics
    int            h_due[$];
    logic [AW-1:0] h_addr[$];
    logic [AW-1:0] cpu_ptr;

    function automatic logic [DW-1:0] hub_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // cycle engine: drives hub model and compares against reference every clock
    initial begin
        bit exp_req, exp_cgnt, pop_ok, arr;
        logic [DW-1:0] arr_data;
        int rot;
        start = 0; pop = 0; cpu_req = 0; start_addr = '0; cpu_addr = '0;
        hub_gnt = 0; hub_rdata = '0; cpu_ptr = 17'h00040;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                m_run = 0; m_addr = '0; m_pv = 0; m_pd = '0;
                m_q.delete(); m_pend_due.delete(); m_pend_addr.delete();
                h_due.delete(); h_addr.delete();
                start = 0; pop = 0; cpu_req = 0; hub_gnt = 0;
                cyc++;
                continue;
            end
            start      = drv_start;
            start_addr = drv_addr;
            pop        = (pop_period != 0) && ((cyc % pop_period) == 0);
            cpu_req    = drv_cpu;
            cpu_addr   = cpu_ptr;
            #1;
            rot     = cyc % 8;
            hub_gnt = hub_req && (hub_addr[2:0] == 3'(rot));
            if (h_due.size() > 0 && h_due[0] == cyc) begin
                hub_rdata = hub_word(h_addr[0]);
                void'(h_due.pop_front());
                void'(h_addr.pop_front());
            end else begin
                hub_rdata = 32'hBAD00000 ^ 32'(cyc);
            end
            if (hub_gnt) begin
                h_due.push_back(cyc + LAT);
                h_addr.push_back(hub_addr);
            end
            exp_req  = m_run && (m_q.size() < MARK) && (m_q.size() + m_pend_due.size() < DEPTH);
            exp_cgnt = cpu_req && !exp_req && hub_gnt;
            #1;
            chk(hub_req === (exp_req | cpu_req), "R4 hub_req", 64'(hub_req), 64'(exp_req | cpu_req));
            if (exp_req)
                chk(hub_addr === m_addr, "R5 hub_addr of prefetch", 64'(hub_addr), 64'(m_addr));
            else if (cpu_req)
                chk(hub_addr === cpu_addr, "R7 hub_addr passes processor", 64'(hub_addr), 64'(cpu_addr));
            chk(cpu_gnt === exp_cgnt, "R7 cpu_gnt", 64'(cpu_gnt), 64'(exp_cgnt));
            chk(pop_valid === m_pv, "R8 pop_valid", 64'(pop_valid), 64'(m_pv));
            if (m_pv)
                chk(pop_data === m_pd, "R5 pop_data order", 64'(pop_data), 64'(m_pd));

            if (pop_valid && first_pv_cyc < 0) begin
                first_pv_cyc  = cyc;
                first_pv_data = pop_data;
            end
            if (hub_gnt && !cpu_gnt && !start) begin
                fifo_grants++;
                if (first_gnt_cyc < 0) first_gnt_cyc = cyc;
            end
            if (cpu_gnt) begin
                cpu_grants++;
                cpu_ptr = cpu_ptr + 1'b1;
            end

            // model update for the end of this cycle
            arr = (m_pend_due.size() > 0) && (m_pend_due[0] == cyc);
            arr_data = '0;
            if (arr) begin
                arr_data = hub_word(m_pend_addr[0]);
                void'(m_pend_due.pop_front());
                void'(m_pend_addr.pop_front());
            end
            if (start) begin
                m_q.delete(); m_pend_due.delete(); m_pend_addr.delete();
                m_run = 1; m_addr = start_addr; m_pv = 0;
                first_gnt_cyc = -1; first_pv_cyc = -1;
            end else begin
                pop_ok = pop && (m_q.size() > 0);
                if (pop && m_q.size() == 0) empty_pops++;
                if (pop_ok && arr) coincide++;          // R9 coincidence
                if (pop_ok) begin
                    m_pd = m_q.pop_front();
                    m_pv = 1;
                end else begin
                    m_pv = 0;
                end
                if (arr) m_q.push_back(arr_data);
                if (exp_req && hub_gnt) begin
                    m_pend_due.push_back(cyc + LAT);
                    m_pend_addr.push_back(m_addr);
                    m_addr = m_addr + 1'b1;
                end
            end
            cyc++;
        end
    end

    task automatic do_start(input logic [AW-1:0] a);
        @(posedge clk); #2;
        drv_start = 1; drv_addr = a;
        @(posedge clk); #2;
        drv_start = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // scenario
    initial begin
        rst_n = 0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1;

        // R1: idle after reset, processor owns the hub
        drv_cpu = 1;
        wait_cycles(24);
        @(negedge clk); #3;
        chk(hub_req === 1'b1 && hub_addr === cpu_addr, "R1 idle hub follows processor",
            64'({hub_req, hub_addr}), 64'({1'b1, cpu_addr}));
        chk(pop_valid === 1'b0, "R1 pop_valid idle", 64'(pop_valid), 0);
        chk(cpu_grants > 0, "R1 processor granted while idle", 64'(cpu_grants), 1);
        chk(fifo_grants == 0, "R1 no prefetch grant before start", 64'(fifo_grants), 0);

        // R3/R4: full refill from empty with no pops
        drv_cpu = 0;
        fifo_grants = 0;
        do_start(17'h00100);
        fifo_grants = 0;
        wait_cycles(80);
        @(negedge clk); #3;
        chk(fifo_grants == DEPTH, "R3 longs fetched in full refill", 64'(fifo_grants), 64'(DEPTH));
        chk(hub_req === 1'b0, "R4 no request when full", 64'(hub_req), 0);

        // R6/R2/R8: restart with pop held high; first pops land on empty storage
        pop_period = 1;
        empty_pops = 0;
        do_start(17'h00200);
        wait_cycles(40);
        chk(first_pv_cyc - first_gnt_cyc == LAT + 2, "R6 first grant to first pop_valid",
            64'(first_pv_cyc - first_gnt_cyc), 64'(LAT + 2));
        chk(first_pv_data === hub_word(17'h00200), "R2 first long after restart",
            64'(first_pv_data), 64'(hub_word(17'h00200)));
        chk(empty_pops > 0, "R8 pops on empty were issued", 64'(empty_pops), 1);

        // steady streams at several rates with the processor competing
        drv_cpu = 1;
        coincide = 0;
        pop_period = 3;  wait_cycles(400);
        pop_period = 9;  wait_cycles(400);
        pop_period = 2;  wait_cycles(300);
        pop_period = 1;  wait_cycles(300);
        chk(coincide > 0, "R9 pop and arrival in one cycle seen", 64'(coincide), 1);

        // R2/R5: restart mid-burst near the top of the address space (wraps)
        do_start(17'h1FFFA);
        wait_cycles(60);
        chk(first_pv_data === hub_word(17'h1FFFA), "R2 first long after mid-burst restart",
            64'(first_pv_data), 64'(hub_word(17'h1FFFA)));
        pop_period = 4;  wait_cycles(200);
        pop_period = 0;  wait_cycles(60);
        @(negedge clk); #3;
        chk(hub_req === 1'b1 && hub_addr === cpu_addr, "R7 processor back after fill",
            64'({hub_req, hub_addr}), 64'({1'b1, cpu_addr}));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule